// File: doc/BRIEF.md
# Time-Multiplexed Cascaded Biquad Equalizer

This block is the equalizer stage of a digital audio path. It runs a cascade of up to ten second-order IIR sections, which gives a filter of up to 20th order. One shared multiplier-accumulator serves every section and consumes one coefficient per clock. Each section keeps its own input and output history. The coefficients sit in an internal word array, and a host loads them through a plain write port.

The host first raises the programming-mode bit and writes the coefficient words. It then drops the bit, picks a section count, and sets the filter-enable bit. Each sample strobe starts one pass through the active sections, and a single valid pulse delivers the result.

An optional crossover mode takes four sections from the budget. Two of them form a low-pass chain that drives the sub-woofer output. The other two form a high-pass chain that drives the main output. Both chains are fed from the equalizer output.

Top module: `biquad_eq`

## Requirements
- R1: An active-low asynchronous reset clears every coefficient word, every section history and both output registers, and holds the valid output low.
- R2: A coefficient write is stored only while the programming-mode bit is 1 and the index is below 50. Word index = section × 5 + tap, with the taps ordered b0, b1, b2, a1, a2. A write made while the bit is 0 leaves the array unchanged.
- R3: While the programming-mode bit is 1, an accepted strobe is answered at the same clock edge. The valid output is registered high, both outputs equal the input sample, and no section history changes.
- R4: While the filter-enable bit is 0, samples pass through exactly as in R3.
- R5: Each section computes y = floor((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) / 2^22). The coefficients are signed Q2.22 values. The result saturates to the signed 24-bit range [−8388608, 8388607].
- R6: With the crossover off, the 4-bit section-count field is clamped to 1..10. A value of 0 runs one section, and any value above 10 runs ten.
- R7: Section s takes the output of section s−1 as its input. The taps are used one per clock, in order. Valid is a one-cycle pulse registered 5 × N clock edges after the edge that accepted the strobe, where N is the number of active sections.
- R8: With the crossover on, the total is clamped to 4..6. The first N−4 sections form the equalizer. The next two sections form a chain that drives the sub output. The last two sections also take the equalizer output, and they drive the main output. With the crossover off, the sub output equals the main output.
- R9: A strobe that arrives while a sample is being processed is dropped and gives no output.
- R10: Each section's history persists from sample to sample and is updated only by filtered samples.
- R11: With the reduced-budget input at 1 and the crossover off, the section count is capped at 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_en_i | input | 1 | Programming mode; enables coefficient writes and forces pass-through |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 6 | Coefficient word index |
| coef_wdata_i | input | 24 | Coefficient value, signed Q2.22 |
| filt_en_i | input | 1 | Filter enable |
| split_en_i | input | 1 | Crossover mode enable |
| tight_clk_i | input | 1 | Reduced section budget (at most nine sections) |
| band_cnt_i | input | 4 | Requested total section count |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 24 | Input sample, signed |
| out_valid_o | output | 1 | Result valid pulse |
| out_main_o | output | 24 | Main output (high band when the crossover is on) |
| out_sub_o | output | 24 | Sub-woofer output |

## Verification
The assertions run on every cycle. They check that the coefficient array stays frozen outside programming mode, that programming-mode samples come back unchanged one edge later, and that the taps step in order without gaps. They also check that every history update targets an existing section, that the latched section totals stay inside their clamp ranges, and that valid never rises while a pass is still in flight.

Only the bench scenarios can show the arithmetic results. These cover the cascade and crossover routing, saturation, history carried across samples, and clamping. They also cover the exact latency per section count and the dropping of overlapping strobes. To check them, the bench compares the outputs with a bit-exact model of the section equation.

// File: rtl/biquad_eq_pkg.sv
package biquad_eq_pkg;
  localparam int DATA_W = 24;
  localparam int COEF_W = 24;
  localparam int TAPS   = 5;
  localparam int ACC_W  = DATA_W + COEF_W + 4;

  typedef enum logic [2:0] {
    K_B0 = 3'd0,
    K_B1 = 3'd1,
    K_B2 = 3'd2,
    K_A1 = 3'd3,
    K_A2 = 3'd4
  } tap_e;
endpackage

// File: rtl/biquad_coef_ram.sv
module biquad_coef_ram
  import biquad_eq_pkg::*;
#(
  parameter int DEPTH  = 50,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [COEF_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] DEPTH_L = DEPTH[ADDR_W:0];

  logic [DEPTH-1:0][COEF_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (prog_i && we_i && ({1'b0, waddr_i} < DEPTH_L)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R2: the array only moves under programming mode
  a_r2_frozen_outside_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_i && we_i) |=> $stable(mem_q));
endmodule

// File: rtl/biquad_state_bank.sv
module biquad_state_bank
  import biquad_eq_pkg::*;
#(
  parameter int NSEC  = 10,
  parameter int SEC_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [SEC_W-1:0]         sec_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  output logic signed [DATA_W-1:0] x1_o,
  output logic signed [DATA_W-1:0] x2_o,
  output logic signed [DATA_W-1:0] y1_o,
  output logic signed [DATA_W-1:0] y2_o
);
  logic [NSEC-1:0][DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (upd_i) begin
      x2_q[sec_i] <= x1_q[sec_i];
      x1_q[sec_i] <= x_i;
      y2_q[sec_i] <= y1_q[sec_i];
      y1_q[sec_i] <= y_i;
    end
  end

  assign x1_o = $signed(x1_q[sec_i]);
  assign x2_o = $signed(x2_q[sec_i]);
  assign y1_o = $signed(y1_q[sec_i]);
  assign y2_o = $signed(y2_q[sec_i]);

  // R10: history writes only target existing sections
  a_r10_sec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (sec_i < SEC_W'(NSEC)));
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac
  import biquad_eq_pkg::*;
#(
  parameter int FRAC_W = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  tap_e                     tap_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] opnd_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

  logic signed [COEF_W+DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]         term, sum, shf, acc_q;

  assign prod = coef_i * opnd_i;

  always_comb begin
    term = ACC_W'(prod);
    if (tap_i == K_A1 || tap_i == K_A2) term = -term;
    sum = ((tap_i == K_B0) ? '0 : acc_q) + term;
    shf = sum >>> FRAC_W;
    if (shf > MAXV)      y_o = MAXV[DATA_W-1:0];
    else if (shf < MINV) y_o = MINV[DATA_W-1:0];
    else                 y_o = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum;
  end

  // R7: taps advance one per clock, in order, with no gap inside a section
  a_r7_tap_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tap_i != K_A2) |=> (en_i && (3'(tap_i) == 3'($past(tap_i)) + 3'd1)));
endmodule

// File: rtl/biquad_eq.sv
module biquad_eq
  import biquad_eq_pkg::*;
#(
  parameter int MAX_SEC   = 10,
  parameter int TIGHT_MAX = 9,
  parameter int SPLIT_SEC = 4,
  parameter int SPLIT_MAX = 6,
  parameter int FRAC_W    = 22,
  parameter int BAND_W    = 4,
  parameter int ADDR_W    = $clog2(MAX_SEC * TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_wdata_i,
  input  logic              filt_en_i,
  input  logic              split_en_i,
  input  logic              tight_clk_i,
  input  logic [BAND_W-1:0] band_cnt_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_main_o,
  output logic [DATA_W-1:0] out_sub_o
);
  localparam int DEPTH = MAX_SEC * TAPS;
  localparam int SEC_W = $clog2(MAX_SEC + 1);

  logic              run_q, split_q, out_valid_q;
  tap_e              tap_q;
  logic [SEC_W-1:0]  sec_q, last_q, eqn_q;
  logic signed [DATA_W-1:0] x_q, br_q, sub_tmp_q, main_q, sub_q;

  logic [BAND_W-1:0] lim_max, lim_min, tot_c;
  logic [ADDR_W-1:0] raddr;
  logic [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] x1, x2, y1, y2, opnd, y_mac;
  logic              bypass, sec_done, upd;

  // section budget clamp
  always_comb begin
    lim_max = split_en_i ? BAND_W'(SPLIT_MAX) :
              tight_clk_i ? BAND_W'(TIGHT_MAX) : BAND_W'(MAX_SEC);
    lim_min = split_en_i ? BAND_W'(SPLIT_SEC) : BAND_W'(1);
    if (band_cnt_i < lim_min)      tot_c = lim_min;
    else if (band_cnt_i > lim_max) tot_c = lim_max;
    else                           tot_c = band_cnt_i;
  end

  assign bypass   = prog_en_i || !filt_en_i;
  assign sec_done = run_q && (tap_q == K_A2);
  assign upd      = sec_done;
  assign raddr    = ADDR_W'(sec_q) * ADDR_W'(TAPS) + ADDR_W'(tap_q);

  biquad_coef_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (prog_en_i),
    .we_i    (coef_we_i),
    .waddr_i (coef_addr_i),
    .wdata_i (coef_wdata_i),
    .raddr_i (raddr),
    .rdata_o (coef)
  );

  biquad_state_bank #(.NSEC(MAX_SEC), .SEC_W(SEC_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .sec_i  (sec_q),
    .x_i    (x_q),
    .y_i    (y_mac),
    .x1_o   (x1),
    .x2_o   (x2),
    .y1_o   (y1),
    .y2_o   (y2)
  );

  always_comb begin
    unique case (tap_q)
      K_B1:    opnd = x1;
      K_B2:    opnd = x2;
      K_A1:    opnd = y1;
      K_A2:    opnd = y2;
      default: opnd = x_q;
    endcase
  end

  biquad_mac #(.FRAC_W(FRAC_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .tap_i  (tap_q),
    .coef_i ($signed(coef)),
    .opnd_i (opnd),
    .y_o    (y_mac)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      split_q     <= 1'b0;
      out_valid_q <= 1'b0;
      tap_q       <= K_B0;
      sec_q       <= '0;
      last_q      <= '0;
      eqn_q       <= '0;
      x_q         <= '0;
      br_q        <= '0;
      sub_tmp_q   <= '0;
      main_q      <= '0;
      sub_q       <= '0;
    end else begin
      out_valid_q <= 1'b0;
      if (!run_q) begin
        if (in_valid_i) begin
          if (bypass) begin
            out_valid_q <= 1'b1;
            main_q      <= $signed(in_data_i);
            sub_q       <= $signed(in_data_i);
          end else begin
            run_q   <= 1'b1;
            sec_q   <= '0;
            tap_q   <= K_B0;
            x_q     <= $signed(in_data_i);
            br_q    <= $signed(in_data_i);
            split_q <= split_en_i;
            last_q  <= SEC_W'(tot_c) - SEC_W'(1);
            eqn_q   <= split_en_i ? SEC_W'(tot_c) - SEC_W'(SPLIT_SEC) : SEC_W'(tot_c);
          end
        end
      end else if (!sec_done) begin
        tap_q <= tap_e'(tap_q + 3'd1);
      end else begin
        tap_q <= K_B0;
        if (sec_q == last_q) begin
          run_q       <= 1'b0;
          out_valid_q <= 1'b1;
          main_q      <= y_mac;
          sub_q       <= split_q ? sub_tmp_q : y_mac;
        end else begin
          sec_q <= sec_q + SEC_W'(1);
          x_q   <= y_mac;
          if (split_q) begin
            // equalizer output feeds both crossover chains
            if (sec_q + SEC_W'(1) == eqn_q) br_q <= y_mac;
            if (sec_q == eqn_q + SEC_W'(1)) begin
              sub_tmp_q <= y_mac;
              x_q       <= br_q;
            end
          end
        end
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_main_o  = main_q;
  assign out_sub_o   = sub_q;

  a_r3_prog_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && prog_en_i && !run_q) |=>
      (out_valid_o && out_main_o == $past(in_data_i) && out_sub_o == $past(in_data_i)));

  a_r7_valid_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !run_q);

  a_r6_total_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (last_q < SEC_W'(MAX_SEC)));

  a_r8_split_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && split_q) |-> (last_q >= SEC_W'(SPLIT_SEC - 1) && last_q <= SEC_W'(SPLIT_MAX - 1)));
endmodule

// File: tb/biquad_eq_bench.sv
module biquad_eq_bench;
  logic        clk_i = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog = 1'b0, we = 1'b0, filt = 1'b0, split = 1'b0, tight = 1'b0;
  logic [5:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [3:0]  band = '0;
  logic        in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_valid;
  logic [23:0] out_main, out_sub;

  biquad_eq u_biquad_eq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .prog_en_i    (prog),
    .coef_we_i    (we),
    .coef_addr_i  (addr),
    .coef_wdata_i (wdata),
    .filt_en_i    (filt),
    .split_en_i   (split),
    .tight_clk_i  (tight),
    .band_cnt_i   (band),
    .in_valid_i   (in_valid),
    .in_data_i    (in_data),
    .out_valid_o  (out_valid),
    .out_main_o   (out_main),
    .out_sub_o    (out_sub)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic [23:0] m;
    logic [23:0] s;
    int          t0;
    int          lat;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  exp_t   mon_e;
  int     cyc = 0, n_out = 0, ntot = 0, npass = 0;
  longint cf[50];
  longint mx1[10], mx2[10], my1[10], my2[10];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint ex);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, ex);
  endtask

  function automatic longint sat24(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint msec(int s, longint x);
    longint acc, y;
    int b;
    b = s * 5;
    acc = cf[b]*x + cf[b+1]*mx1[s] + cf[b+2]*mx2[s] - cf[b+3]*my1[s] - cf[b+4]*my2[s];
    y = sat24(acc >>> 22);
    mx2[s] = mx1[s]; mx1[s] = x; my2[s] = my1[s]; my1[s] = y;
    return y;
  endfunction

  function automatic int mtot();
    int lo, hi, t;
    lo = split ? 4 : 1;
    hi = split ? 6 : (tight ? 9 : 10);
    t = int'(band);
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    return t;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 50; i++) cf[i] = 0;
    for (int i = 0; i < 10; i++) begin
      mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0;
    end
  endfunction

  function automatic exp_t predict(longint x, string tag);
    exp_t e;
    int t, n;
    longint v, lo, hi;
    if (prog || !filt) begin
      e.m = 24'(x); e.s = 24'(x); e.lat = 0;
    end else begin
      t = mtot();
      v = x;
      if (split) begin
        n = t - 4;
        for (int s = 0; s < n; s++) v = msec(s, v);
        lo = msec(n, v);
        lo = msec(n + 1, lo);
        hi = msec(n + 2, v);
        hi = msec(n + 3, hi);
        e.m = 24'(hi); e.s = 24'(lo);
      end else begin
        for (int s = 0; s < t; s++) v = msec(s, v);
        e.m = 24'(v); e.s = 24'(v);
      end
      e.lat = 5 * t;
    end
    e.tag = tag;
    e.t0 = 0;
    return e;
  endfunction

  task automatic wc(int a, longint v);
    @(negedge clk_i);
    we = 1'b1; addr = 6'(a); wdata = 24'(v);
    if (prog && a < 50) cf[a] = v;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic send(longint x, string tag);
    exp_t e;
    e = predict(x, tag);
    @(negedge clk_i);
    in_valid = 1'b1; in_data = 24'(x);
    e.t0 = cyc + 1;
    sb.push_back(e);
    @(negedge clk_i);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected output", 1, 0);
      end else begin
        mon_e = sb.pop_front();
        chk(out_main == mon_e.m, mon_e.tag, "main", longint'($signed(out_main)), longint'($signed(mon_e.m)));
        chk(out_sub == mon_e.s, mon_e.tag, "sub", longint'($signed(out_sub)), longint'($signed(mon_e.s)));
        chk(cyc - mon_e.t0 == mon_e.lat, mon_e.tag, "latency", cyc - mon_e.t0, mon_e.lat);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", "run state", 0, 1);
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    exp_t e;
    int   prev;
    model_clear();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(out_valid == 1'b0 && out_main == '0 && out_sub == '0, "R1", "outputs in reset",
        longint'(out_main), 0);
    rst_n = 1'b1;
    @(negedge clk_i);
    chk(out_valid == 1'b0, "R1", "valid after reset", longint'(out_valid), 0);

    // R2: load all sections in programming mode
    prog = 1'b1;
    for (int s = 0; s < 10; s++) begin
      wc(s*5,     2097152 + s*1000);
      wc(s*5 + 1, 1048576 - s*777);
      wc(s*5 + 2, 524288);
      wc(s*5 + 3, -786432);
      wc(s*5 + 4, 262144);
    end
    send(12345, "R3");
    send(-4000, "R3");

    // R2: write outside programming mode is ignored
    prog = 1'b0;
    wc(0, 4194303);
    filt = 1'b1; band = 4'd3;
    send(100000, "R2");
    send(-250000, "R7");
    send(3000000, "R10");
    send(0, "R10");

    // R3/R10: programming-mode sample leaves histories intact
    prog = 1'b1;
    send(777777, "R3");
    prog = 1'b0;
    send(55555, "R10");

    // R4: filter disabled passes through
    filt = 1'b0;
    send(-123456, "R4");
    filt = 1'b1;

    // R6 / R11: clamping
    band = 4'd0;  send(400000, "R6");
    band = 4'd15; send(-400000, "R6");
    band = 4'd10; send(90000, "R6");
    tight = 1'b1; band = 4'd15; send(250000, "R11");
    tight = 1'b0;

    // R8: crossover
    split = 1'b1;
    band = 4'd6;  send(1500000, "R8");
    send(-800000, "R8");
    band = 4'd2;  send(600000, "R8");
    band = 4'd15; send(-2000000, "R8");
    tight = 1'b1; band = 4'd5; send(700000, "R8");
    tight = 1'b0; split = 1'b0;

    // R9: overlapping strobe dropped
    band = 4'd3;
    prev = n_out;
    e = predict(222222, "R9");
    @(negedge clk_i);
    in_valid = 1'b1; in_data = 24'(222222);
    e.t0 = cyc + 1;
    sb.push_back(e);
    @(negedge clk_i); in_valid = 1'b0;
    repeat (2) @(negedge clk_i);
    in_valid = 1'b1; in_data = 24'(-999);
    @(negedge clk_i); in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk_i);
    repeat (60) @(negedge clk_i);
    chk(n_out == prev + 1, "R9", "output count", n_out - prev, 1);

    // R5: saturation
    prog = 1'b1;
    wc(0, 8388607); wc(1, 0); wc(2, 0); wc(3, 0); wc(4, 0);
    prog = 1'b0;
    band = 4'd1;
    send(8388607, "R5");
    send(-8388608, "R5");
    send(1000, "R5");

    // R1: mid-run reset clears coefficients and histories
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk_i);
    chk(out_main == '0 && out_sub == '0 && out_valid == 1'b0, "R1", "outputs after reset",
        longint'(out_main), 0);
    rst_n = 1'b1;
    band = 4'd3;
    send(5000, "R1");

    repeat (5) @(negedge clk_i);
    chk(sb.size() == 0, "R7", "pending outputs", sb.size(), 0);
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end
endmodule